// File: doc/BRIEF.md
# Float to Integer Truncating Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer. The output width is `OUT_W`: 32 by default, and 64 for the wide variant. The operand arrives in five parts:

- a 3-bit class code;
- a sign;
- a signed unbiased exponent;
- a mantissa whose leading one sits in its top bit;
- a sticky bit that stands for any nonzero bits already dropped below the mantissa.

A number-class operand has the value `inMant * 2^(inExp - (MANT_W-1))`. The conversion always chops toward zero. No rounding-mode setting takes part in it.

Each result carries two flags. The inexact flag reports that a fraction was thrown away. The invalid flag reports that the operand cannot be represented. On that path the result saturates, and the saturation value depends on the sign. The block takes one operand per cycle on `inValid` and returns the registered result one clock later. Unpacking of encoded formats and exception trapping belong to neighbouring logic.

Top module: `f2i_trunc`

## Requirements
- R1: Results always truncate toward zero for both signs. For example, 2.75 gives 2, -2.75 gives -2, and a magnitude just below 1 gives 0.
- R2: Class code 0 (zero) gives result 0 with both flags clear, whatever the sign, exponent and mantissa.
- R3: A number-class operand (class code 1) with exponent at or above `OUT_W` is an overflow.
- R4: A number-class operand with a negative exponent gives 0 with inexact set and invalid clear. This holds for either sign.
- R5: For an in-range number, inexact is set exactly when a mantissa bit below the integer LSB or the sticky input is nonzero. An exact integer leaves it clear.
- R6: An in-range magnitude overflows when it exceeds 2^(OUT_W-1), or when it equals 2^(OUT_W-1) with positive sign. A negative operand of magnitude exactly 2^(OUT_W-1) gives the most negative integer without invalid.
- R7: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are all treated as overflow.
- R8: On overflow, invalid is set and inexact is cleared. The result is the largest positive integer (0x7FFFFFFF at 32 bits) for a positive sign, and the most negative integer (0x80000000) for a negative sign.
- R9: A negative in-range result is the two's complement of the truncated magnitude.
- R10: The result and flags update one clock after `inValid` is high and hold otherwise. `outValid` is `inValid` delayed by one clock. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| inClass | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| inSign | input | 1 | Operand sign, 1 = negative |
| inExp | input | EXP_W | Signed unbiased exponent |
| inMant | input | MANT_W | Mantissa, leading one at bit MANT_W-1 |
| inSticky | input | 1 | OR of bits already below the mantissa |
| outValid | output | 1 | Result registered this cycle |
| outResult | output | OUT_W | Signed integer result |
| outInexact | output | 1 | Fraction discarded |
| outInvalid | output | 1 | Operand not representable; result saturated |

## Verification
The bench targets the boundaries where a wrong design fails quietly. At magnitude exactly 2^31, a symmetric overflow test would wrongly saturate -2^31, and a missing test would let +2^31 wrap to a negative number. On an overflowing operand that also carries sticky, a design that ORs flags instead of swapping them would report inexact together with invalid. Negative exponents and near-one fractions of either sign expose rounding-mode leakage or a stray -0 as a nonzero result. Exact integers check that inexact is not raised spuriously. Every NaN, infinity and unused class code must saturate by sign, not pass mantissa bits through.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Operand class codes seen on inClass
  localparam logic [2:0] CLS_ZERO = 3'd0;
  localparam logic [2:0] CLS_NUM  = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic forceZero;  // zero class: clean zero
    logic belowOne;   // number with negative exponent
    logic forceSat;   // non-number class or exponent past range
  } ctl_t;

endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
#(
  parameter int OUT_W = 32,
  parameter int EXP_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              inClass,
  input  logic signed [EXP_W-1:0] inExp,
  output ctl_t                    ctl,
  output logic                    outValid
);

  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(OUT_W);

  logic isNum;
  logic isZero;

  always_comb begin
    isNum         = (inClass == CLS_NUM);
    isZero        = (inClass == CLS_ZERO);
    ctl.load      = inValid;
    ctl.forceZero = isZero;
    ctl.belowOne  = isNum && (inExp < 0);
    // every class that is neither zero nor number saturates (R7); so does a large exponent (R3)
    ctl.forceSat  = !isZero && (!isNum || (inExp >= EXP_LIM));
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r10_valid_lag: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r10_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int MANT_W = 32,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  input  logic                    inSticky,
  output logic [OUT_W-1:0]        outResult,
  output logic                    outInexact,
  output logic                    outInvalid
);

  localparam int WIDE_W = OUT_W + MANT_W;
  localparam logic [OUT_W-1:0] MIN_MAG = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] POS_SAT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_SAT = MIN_MAG;

  logic [EXP_W-1:0]  shAmt;
  logic [WIDE_W-1:0] wide;
  logic [OUT_W-1:0]  mag;
  logic              dropped;
  logic              ovf;
  logic [OUT_W-1:0]  nextRes;
  logic              nextNx;
  logic              nextNv;

  // integer part lands above bit MANT_W once shifted by exponent+1
  always_comb begin
    shAmt   = inExp + EXP_W'(1);
    wide    = {{OUT_W{1'b0}}, inMant} << shAmt;
    mag     = wide[WIDE_W-1:MANT_W];
    dropped = (|wide[MANT_W-1:0]) | inSticky;
    ovf     = (mag > MIN_MAG) || ((mag == MIN_MAG) && !inSign);
  end

  always_comb begin
    nextRes = '0;
    nextNx  = 1'b0;
    nextNv  = 1'b0;
    if (ctl.forceZero) begin
      nextRes = '0;
    end else if (ctl.forceSat || (!ctl.belowOne && ovf)) begin
      nextRes = inSign ? NEG_SAT : POS_SAT;
      nextNv  = 1'b1;
    end else if (ctl.belowOne) begin
      nextNx  = (|inMant) | inSticky;
    end else begin
      nextRes = inSign ? (~mag + OUT_W'(1)) : mag;
      nextNx  = dropped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult  <= '0;
      outInexact <= 1'b0;
      outInvalid <= 1'b0;
    end else if (ctl.load) begin
      outResult  <= nextRes;
      outInexact <= nextNx;
      outInvalid <= nextNv;
    end
  end

  a_r2_zero_clean: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.forceZero) |=> (outResult == '0) && !outInexact && !outInvalid);
  a_r7_sat_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.forceSat) |=> outInvalid);
  a_r4_below_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.belowOne) |=> (outResult == '0) && !outInvalid);
  a_r8_flag_swap: assert property (@(posedge clk) disable iff (!rstN)
    outInvalid |-> !outInexact);
  a_r8_sat_value: assert property (@(posedge clk) disable iff (!rstN)
    outInvalid |-> ((outResult == POS_SAT) || (outResult == NEG_SAT)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(outResult) && $stable(outInexact) && $stable(outInvalid));

endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
  import f2i_pkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int MANT_W = 32,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              inClass,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  input  logic                    inSticky,
  output logic                    outValid,
  output logic [OUT_W-1:0]        outResult,
  output logic                    outInexact,
  output logic                    outInvalid
);

  ctl_t ctl;

  f2i_ctrl #(.OUT_W(OUT_W), .EXP_W(EXP_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inClass (inClass),
    .inExp   (inExp),
    .ctl     (ctl),
    .outValid(outValid)
  );

  f2i_datapath #(.OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inSign    (inSign),
    .inExp     (inExp),
    .inMant    (inMant),
    .inSticky  (inSticky),
    .outResult (outResult),
    .outInexact(outInexact),
    .outInvalid(outInvalid)
  );

endmodule

// File: tb/f2i_trunc_tb.sv
`timescale 1ns/1ps
module f2i_trunc_tb;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [2:0]        inClass = 3'd0;
  logic              inSign = 1'b0;
  logic signed [11:0] inExp = '0;
  logic [31:0]       inMant = '0;
  logic              inSticky = 1'b0;
  logic              outValid;
  logic [31:0]       outResult;
  logic              outInexact;
  logic              outInvalid;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  f2i_trunc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .inSign(inSign), .inExp(inExp), .inMant(inMant), .inSticky(inSticky),
    .outValid(outValid), .outResult(outResult),
    .outInexact(outInexact), .outInvalid(outInvalid)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  cls;
    logic        sgn;
    logic [11:0] ex;
    logic [31:0] mant;
    logic        st;
    logic [31:0] res;
    logic        nx;
    logic        nv;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 3'd1, 1'b0, 12'd0,    32'h8000_0000, 1'b0, 32'h0000_0001, 1'b0, 1'b0}, // R5 exact 1.0
    '{4'd1, 3'd1, 1'b0, 12'd1,    32'hB000_0000, 1'b0, 32'h0000_0002, 1'b1, 1'b0}, // R1 2.75
    '{4'd1, 3'd1, 1'b1, 12'd1,    32'hB000_0000, 1'b0, 32'hFFFF_FFFE, 1'b1, 1'b0}, // R1 R9 -2.75
    '{4'd9, 3'd1, 1'b1, 12'd2,    32'hA000_0000, 1'b0, 32'hFFFF_FFFB, 1'b0, 1'b0}, // R9 -5
    '{4'd5, 3'd1, 1'b0, 12'd0,    32'h8000_0000, 1'b1, 32'h0000_0001, 1'b1, 1'b0}, // R5 sticky only
    '{4'd4, 3'd1, 1'b0, 12'hFFF,  32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R4 0.5
    '{4'd4, 3'd1, 1'b1, 12'hFEC,  32'hC000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R4 tiny negative
    '{4'd2, 3'd0, 1'b1, 12'd40,   32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R2 zero class
    '{4'd6, 3'd1, 1'b1, 12'd31,   32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b0}, // R6 -2^31 fits
    '{4'd6, 3'd1, 1'b0, 12'd31,   32'h8000_0000, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R6 +2^31 overflows
    '{4'd6, 3'd1, 1'b1, 12'd31,   32'h8000_0001, 1'b0, 32'h8000_0000, 1'b0, 1'b1}, // R6 -(2^31+1)
    '{4'd1, 3'd1, 1'b0, 12'd30,   32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R1 largest in range
    '{4'd8, 3'd1, 1'b0, 12'd32,   32'hC000_0000, 1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R3 R8 flag swap
    '{4'd3, 3'd1, 1'b1, 12'd100,  32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b1}, // R3 big exponent
    '{4'd7, 3'd2, 1'b0, 12'd0,    32'h8000_0000, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R7 +inf
    '{4'd7, 3'd3, 1'b1, 12'd0,    32'hC000_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b1}, // R7 quiet NaN
    '{4'd7, 3'd4, 1'b0, 12'd0,    32'hA000_0000, 1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R7 signalling NaN
    '{4'd7, 3'd6, 1'b1, 12'd3,    32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b1}, // R7 unused code
    '{4'd6, 3'd1, 1'b1, 12'd31,   32'h8000_0000, 1'b1, 32'h8000_0000, 1'b1, 1'b0}, // R6 -2^31 with sticky
    '{4'd1, 3'd1, 1'b1, 12'hFFF,  32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b1, 1'b0}  // R1 -0.99 to 0
  };

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] c, logic s, logic [11:0] e, logic [31:0] m, logic st);
    @(negedge clk);
    inClass = c; inSign = s; inExp = e; inMant = m; inSticky = st;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [33:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset", {outValid, outInvalid, outInexact, outResult[30:0]}, '0);
    check("R10 reset result", {2'b0, outResult}, '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cls, VECS[i].sgn, VECS[i].ex, VECS[i].mant, VECS[i].st);
      nRun++;
      if ({outResult, outInexact, outInvalid} !== {VECS[i].res, VECS[i].nx, VECS[i].nv}) begin
        nFail++;
        $display("FAIL R%0d vector %0d actual=%h/%b/%b expected=%h/%b/%b", VECS[i].req, i,
                 outResult, outInexact, outInvalid, VECS[i].res, VECS[i].nx, VECS[i].nv);
      end
      check("R10 valid pulse", {33'b0, outValid}, 34'd1);
    end

    // R10 hold: inputs change without inValid, outputs stay put
    apply(3'd1, 1'b1, 12'd3, 32'hC000_0000, 1'b0);
    check("R9 -12", {outInexact, outInvalid, outResult}, {2'b00, 32'hFFFF_FFF4});
    held = {outInexact, outInvalid, outResult};
    @(negedge clk);
    inClass = 3'd2; inSign = 1'b0; inExp = 12'd50; inMant = 32'hFFFF_FFFF; inSticky = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 hold", {outInexact, outInvalid, outResult}, held);
    check("R10 valid low", {33'b0, outValid}, 34'd0);

    // R10 back-to-back operands, one per cycle
    @(negedge clk);
    inClass = 3'd1; inSign = 1'b0; inExp = 12'd4; inMant = 32'h8800_0000; inSticky = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    check("R5 17 exact", {outInexact, outInvalid, outResult}, {2'b00, 32'd17});
    inClass = 3'd0;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 back-to-back zero", {outInexact, outInvalid, outResult}, 34'd0);
    check("R10 valid stays", {33'b0, outValid}, 34'd1);

    // R10 reset clears a saturated result
    apply(3'd2, 1'b1, 12'd0, 32'h8000_0000, 1'b0);
    check("R8 -inf", {outInexact, outInvalid, outResult}, {2'b01, 32'h8000_0000});
    rstN = 1'b0;
    @(negedge clk);
    check("R10 reset clears", {outValid, outInexact, outInvalid, outResult[30:0]}, 34'd0);
    rstN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule